// File: doc/BRIEF.md
# Host Clock Output with Clock Tail

This block produces the clock that a radio device hands to its host microcontroller. While the crystal oscillator is enabled, the output is the reference clock divided by a ratio that can be programmed. When the host clears the oscillator-enable input, the output keeps running for a programmed number of further pulses. This tail gives the host time to reach idle before its clock goes away.

The crystal keep-alive output stays high until the last tail pulse has ended. The block then enters sleep. In sleep it either passes on a slow external clock of about 32 kHz, once that clock has been synchronised, or it holds the output low.

Clock sources are switched only at phase boundaries, so no shortened high or low phase appears on the output. The ratio, the tail length and the sleep-clock enable are kept in registers. These registers change only on a write strobe or a reset, so they survive any number of sleep periods.

Top module: `hostclk_out`

## Requirements
- R1: After reset `host_clk` is 0 and `xtal_keep` is 1. The settings take their defaults: ratio 5, tail 128, sleep clock off.
- R2: While running, `host_clk` is high for exactly `ratio` reference cycles and then low for `ratio` cycles. A ratio of 0 behaves as 1.
- R3: The settings load from `cfg_div`, `cfg_tail` and `cfg_slow_en` only on a clock edge with `cfg_we` high. They are otherwise retained, including across sleep, until reset.
- R4: Once `osc_en` is sampled low, `host_clk` shows exactly `tail` falling edges before sleep. A pulse that is already high counts as the first of them. A tail of 0 behaves as 1.
- R5: `xtal_keep` falls on the same edge as the last tail falling edge of `host_clk`, and not before.
- R6: If `osc_en` is sampled high during the tail, the tail is abandoned. The divided clock continues and `xtal_keep` stays 1.
- R7: In sleep with the sleep clock enabled, `host_clk` follows the slow clock after a two-flop synchroniser. A gate opens and closes only while the slow clock is low, so only whole phases reach the output.
- R8: In sleep with the sleep clock disabled, `host_clk` is held at 0.
- R9: If `osc_en` is high in sleep, the block returns to the divided clock once `host_clk` is low, and `xtal_keep` returns to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high power-on reset |
| cfg_we | input | 1 | Setting write strobe |
| cfg_div | input | 8 | Division ratio to load |
| cfg_tail | input | 10 | Tail pulse count to load |
| cfg_slow_en | input | 1 | Sleep-clock enable to load |
| osc_en | input | 1 | Oscillator enable from the host |
| slow_clk | input | 1 | Slow sleep clock, asynchronous |
| host_clk | output | 1 | Clock to the host, registered |
| xtal_keep | output | 1 | Crystal keep-alive request, registered |

## Verification
Two events can fall in the same cycle. One is the divider's falling toggle and the other is the edge that first samples `osc_en` low; when they coincide, that fall must count as tail pulse one. The vector loop uses ratios of 1, 2, 3 and 7, so the drop of `osc_en` lands at differing divider phases, and the ratio of 1 forces the coincidence. Each case is judged by counting the output falling edges up to and including the edge where `xtal_keep` drops, which must equal the programmed tail.

// File: rtl/hc_pkg.sv
package hc_pkg;
  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_TAIL  = 2'd1,
    ST_SLEEP = 2'd2
  } hc_state_e;
endpackage

// File: rtl/hc_cfg.sv
module hc_cfg #(
  parameter int DW          = 8,
  parameter int TW          = 10,
  parameter int DIV_DEFAULT = 5,
  parameter int TAIL_DEFAULT = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [DW-1:0] div_in,
  input  logic [TW-1:0] tail_in,
  input  logic          slow_in,
  output logic [DW-1:0] div_q,
  output logic [TW-1:0] tail_q,
  output logic          slow_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      div_q  <= DW'(DIV_DEFAULT);
      tail_q <= TW'(TAIL_DEFAULT);
      slow_q <= 1'b0;
    end else if (we) begin
      div_q  <= div_in;
      tail_q <= tail_in;
      slow_q <= slow_in;
    end
  end

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    !we |=> ($stable(div_q) && $stable(tail_q) && $stable(slow_q))); // R3
endmodule

// File: rtl/hc_sync.sv
module hc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;
  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end
  assign q = sh[STAGES-1];
endmodule

// File: rtl/hc_core.sv
module hc_core
  import hc_pkg::*;
#(
  parameter int DW = 8,
  parameter int TW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          osc_en,
  input  logic [DW-1:0] ratio,
  input  logic [TW-1:0] tail,
  input  logic          slow_en,
  input  logic          slow_s,
  output logic          host_clk,
  output logic          xtal_keep
);
  hc_state_e     state_q, state_n;
  logic [DW-1:0] cnt_q, cnt_n, ratio_eff, last_cnt;
  logic [TW-1:0] left_q, left_n, tail_eff, left_eff;
  logic          host_q, host_n, gate_q, gate_n, keep_q;
  logic          tick, fall, tail_act;

  always_comb begin
    ratio_eff = (ratio == '0) ? DW'(1) : ratio;
    tail_eff  = (tail == '0) ? TW'(1) : tail;
    last_cnt  = ratio_eff - DW'(1);
    tick      = (state_q != ST_SLEEP) && (cnt_q == last_cnt);
    fall      = tick && host_q;
    tail_act  = (state_q != ST_SLEEP) && !osc_en;
    left_eff  = (state_q == ST_RUN) ? tail_eff : left_q;
  end

  always_comb begin
    state_n = state_q;
    cnt_n   = cnt_q;
    left_n  = left_q;
    host_n  = host_q;
    gate_n  = gate_q;
    if (state_q == ST_SLEEP) begin
      cnt_n = '0;
      if (osc_en && !host_q) begin
        state_n = ST_RUN;
        gate_n  = 1'b0;
        host_n  = 1'b0;
      end else begin
        if (gate_q) gate_n = !((!slow_en || osc_en) && !slow_s);
        else        gate_n = slow_en && !osc_en && !slow_s;
        host_n = gate_n && slow_s;
      end
    end else begin
      cnt_n  = tick ? '0 : cnt_q + DW'(1);
      host_n = tick ? ~host_q : host_q;
      gate_n = 1'b0;
      if (tail_act) begin
        if (fall && left_eff <= TW'(1)) begin
          state_n = ST_SLEEP;
          cnt_n   = '0;
        end else begin
          state_n = ST_TAIL;
          left_n  = fall ? left_eff - TW'(1) : left_eff;
        end
      end else begin
        state_n = ST_RUN;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RUN;
      cnt_q   <= '0;
      left_q  <= '0;
      host_q  <= 1'b0;
      gate_q  <= 1'b0;
      keep_q  <= 1'b1;
    end else begin
      state_q <= state_n;
      cnt_q   <= cnt_n;
      left_q  <= left_n;
      host_q  <= host_n;
      gate_q  <= gate_n;
      keep_q  <= (state_n != ST_SLEEP);
    end
  end

  assign host_clk  = host_q;
  assign xtal_keep = keep_q;

  AST_DIV_TOGGLE: assert property (@(posedge clk) disable iff (rst)
    ($past(state_q) != ST_SLEEP && state_q != ST_SLEEP && host_q != $past(host_q))
      |-> ($past(cnt_q) == $past(last_cnt))); // R2
  AST_KEEP_DROP_LOW: assert property (@(posedge clk) disable iff (rst)
    $fell(keep_q) |-> !host_q); // R5
  AST_TAIL_ABORT: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_TAIL && osc_en) |=> (state_q == ST_RUN)); // R6
  AST_SLEEP_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && $past(state_q) == ST_SLEEP && host_q) |-> $past(slow_s)); // R7
  AST_SLEEP_OFF: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SLEEP && !gate_q) |-> !host_q); // R8
endmodule

// File: rtl/hostclk_out.sv
module hostclk_out #(
  parameter int DW           = 8,
  parameter int TW           = 10,
  parameter int DIV_DEFAULT  = 5,
  parameter int TAIL_DEFAULT = 128,
  parameter int SYNC_STAGES  = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [DW-1:0] cfg_div,
  input  logic [TW-1:0] cfg_tail,
  input  logic          cfg_slow_en,
  input  logic          osc_en,
  input  logic          slow_clk,
  output logic          host_clk,
  output logic          xtal_keep
);
  logic [DW-1:0] div_q;
  logic [TW-1:0] tail_q;
  logic          slow_q, slow_s;

  hc_cfg #(.DW(DW), .TW(TW), .DIV_DEFAULT(DIV_DEFAULT), .TAIL_DEFAULT(TAIL_DEFAULT)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .div_in(cfg_div), .tail_in(cfg_tail),
    .slow_in(cfg_slow_en), .div_q(div_q), .tail_q(tail_q), .slow_q(slow_q)
  );

  hc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(slow_clk), .q(slow_s)
  );

  hc_core #(.DW(DW), .TW(TW)) u_core (
    .clk(clk), .rst(rst), .osc_en(osc_en), .ratio(div_q), .tail(tail_q),
    .slow_en(slow_q), .slow_s(slow_s), .host_clk(host_clk), .xtal_keep(xtal_keep)
  );
endmodule

// File: tb/hostclk_out_bench.sv
`timescale 1ns/1ps
module hostclk_out_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [7:0] cfg_div = 8'd0;
  logic [9:0] cfg_tail = 10'd0;
  logic       cfg_slow_en = 1'b0;
  logic       osc_en = 1'b1;
  logic       slow_clk = 1'b0;
  logic       host_clk, xtal_keep;
  int         errors = 0;
  int         checks = 0;

  hostclk_out u_hostclk_out (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_div(cfg_div), .cfg_tail(cfg_tail),
    .cfg_slow_en(cfg_slow_en), .osc_en(osc_en), .slow_clk(slow_clk),
    .host_clk(host_clk), .xtal_keep(xtal_keep)
  );

  always #10 clk = ~clk;
  always #800 slow_clk = ~slow_clk;

  // {ratio, tail, expected falls}
  localparam logic [27:0] VEC [4] = '{
    {8'd1, 10'd3, 10'd3},
    {8'd3, 10'd1, 10'd1},
    {8'd7, 10'd20, 10'd20},
    {8'd2, 10'd0, 10'd1}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] d, input logic [9:0] t, input logic s);
    @(negedge clk);
    cfg_div = d; cfg_tail = t; cfg_slow_en = s; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic measure_high(output int n);
    int guard = 0;
    n = 0;
    while (host_clk && guard < 3000) begin @(negedge clk); guard++; end
    while (!host_clk && guard < 3000) begin @(negedge clk); guard++; end
    while (host_clk && guard < 3000) begin @(negedge clk); n++; guard++; end
  endtask

  task automatic run_tail(output int falls, output bit dropped);
    logic prev;
    falls = 0; dropped = 0;
    @(negedge clk);
    prev = host_clk;
    osc_en = 1'b0;
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (prev && !host_clk) falls++;
      prev = host_clk;
      if (!xtal_keep) begin dropped = 1; break; end
    end
  endtask

  task automatic wake();
    @(negedge clk);
    osc_en = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #4_000_000;
    checks++; errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n, f, highs;
    bit d, kept;
    logic prev;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    chk(host_clk == 1'b0, "R1 host_clk after reset", host_clk, 0);
    chk(xtal_keep == 1'b1, "R1 xtal_keep after reset", xtal_keep, 1);
    measure_high(n);
    chk(n == 5, "R1 default ratio", n, 5);
    run_tail(f, d);
    chk(d && f == 128, "R1 default tail", f, 128);
    chk(host_clk == 1'b0, "R8 sleep clock off by default", host_clk, 0);
    wake();
    chk(xtal_keep == 1'b1, "R9 keep returns on wake", xtal_keep, 1);

    // vector table: ratio, then tail length with keep drop
    for (int v = 0; v < 4; v++) begin
      write_cfg(VEC[v][27:20], VEC[v][19:10], 1'b0);
      measure_high(n);
      chk(n == int'(VEC[v][27:20]), "R2 high phase", n, int'(VEC[v][27:20]));
      run_tail(f, d);
      chk(d && f == int'(VEC[v][9:0]), "R4 tail falls", f, int'(VEC[v][9:0]));
      chk(host_clk == 1'b0, "R5 output low at keep drop", host_clk, 0);
      wake();
    end

    // R2 ratio 0 acts as 1
    write_cfg(8'd0, 10'd4, 1'b0);
    measure_high(n);
    chk(n == 1, "R2 ratio zero", n, 1);

    // R6 abort during tail
    write_cfg(8'd3, 10'd50, 1'b0);
    @(negedge clk); osc_en = 1'b0;
    repeat (20) @(negedge clk);
    osc_en = 1'b1;
    kept = 1; highs = 0; prev = host_clk;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      if (!xtal_keep) kept = 0;
      if (!prev && host_clk) highs++;
      prev = host_clk;
    end
    chk(kept, "R6 keep held after abort", kept, 1);
    chk(highs == 100, "R6 clock continues", highs, 100);

    // R8 sleep with slow clock disabled
    write_cfg(8'd2, 10'd2, 1'b0);
    run_tail(f, d);
    highs = 0;
    for (int i = 0; i < 300; i++) begin @(negedge clk); if (host_clk) highs++; end
    chk(highs == 0, "R8 output held low", highs, 0);
    // R9 wake, R3 settings retained across sleep
    wake();
    measure_high(n);
    chk(n == 2, "R3 ratio retained after sleep", n, 2);

    // R7 sleep with slow clock enabled
    write_cfg(8'd4, 10'd3, 1'b1);
    run_tail(f, d);
    chk(d && f == 3, "R4 tail before slow sleep", f, 3);
    measure_high(n);
    chk(n == 40, "R7 slow high phase whole", n, 40);
    chk(xtal_keep == 1'b0, "R7 keep low during slow sleep", xtal_keep, 0);
    wake();
    repeat (45) @(negedge clk);
    chk(xtal_keep == 1'b1, "R9 wake from slow sleep", xtal_keep, 1);
    measure_high(n);
    chk(n == 4, "R9 divided clock after wake", n, 4);

    // R3 inputs ignored without strobe
    @(negedge clk);
    cfg_div = 8'd9; cfg_tail = 10'd9;
    measure_high(n);
    chk(n == 4, "R3 no load without strobe", n, 4);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule